// File: doc/BRIEF.md
# Result Window Compare Monitor

This block watches the stream of conversion results that leave a multi-channel converter sequencer. Each result arrives as a one-cycle valid strobe together with its channel number and a 12-bit value. The block holds a parameterised number of comparators; two by default. Each comparator watches one selected channel and tests every new result from that channel against a 12-bit threshold. The test is either "below the threshold" or "at or above the threshold".

Every result that passes the test adds one to a private match counter. When enough matches have accumulated, the comparator raises a sticky flag. It can also raise an interrupt, if the comparator's interrupt enable is set. The number of matches needed is one more than a 4-bit limit field. While the flag is pending, the counter is parked at zero and further matches are ignored. Software clears the flag with a one-cycle write-1 pulse, after which counting starts again from zero.

All configuration arrives as plain input fields. The register bus that drives them sits outside this block.

Top module: `wcm_monitor`

## Requirements
- R1: A comparator evaluates a result only when its enable bit is 1, the result valid strobe is 1, and the result channel equals its selected channel. Otherwise nothing changes.
- R2: With the condition bit at 0, a result strictly below the threshold is a match. With the condition bit at 1, a result greater than or equal to the threshold is a match. Both comparisons are unsigned 12-bit.
- R3: Each match adds one to the counter, and a non-matching result leaves the counter unchanged, so matches need not be consecutive. The flag sets on the match that brings the total to limit + 1.
- R4: With a limit field of 0, the flag sets on the first match.
- R5: When the flag sets, the counter returns to 0. Matches that arrive while the flag is 1 are not counted. After a clear, limit + 1 fresh matches are needed again.
- R6: Only the selected channel values 0 to 7 and 13 to 17 can produce a match. A selection of 8 to 12, or above 17, never sets the flag.
- R7: The interrupt output of a comparator is 1 exactly when its flag is 1 and its interrupt enable is 1, in the same cycle.
- R8: The flag stays at 1 until a clear pulse is applied. The flag and the counter update on the rising clock edge that follows the result or the clear.
- R9: While the enable bit is 0, the counter is forced to 0 and the flag keeps its value.
- R10: If a flag-set event and a clear pulse fall in the same cycle, the flag ends at 1.
- R11: After synchronous reset, every flag, interrupt and counter is 0.
- R12: The comparators are independent. Each one has its own configuration, clear pulse, counter and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| res_valid | input | 1 | One-cycle strobe: a new result is present |
| res_chan | input | CH_W (5) | Channel number of the result |
| res_data | input | DATA_W (12) | Result value |
| cfg_en | input | NUM_CMP | Per-comparator enable |
| cfg_irq_en | input | NUM_CMP | Per-comparator interrupt enable |
| cfg_ge | input | NUM_CMP | Per-comparator condition: 0 below, 1 at or above |
| cfg_chan | input | NUM_CMP*CH_W | Selected channel, comparator i at bits [i*CH_W +: CH_W] |
| cfg_limit | input | NUM_CMP*CNT_W | Limit field, comparator i at bits [i*CNT_W +: CNT_W] |
| cfg_thresh | input | NUM_CMP*DATA_W | Threshold, comparator i at bits [i*DATA_W +: DATA_W] |
| flag_clr | input | NUM_CMP | One-cycle write-1 clear pulse per comparator |
| cmp_flag | output | NUM_CMP | Sticky compare flag per comparator |
| cmp_irq | output | NUM_CMP | Compare interrupt per comparator |

## Verification
The embedded assertions check the following on every cycle:
- the counter sits at zero while a flag is pending;
- the flag holds until a clear, and falls on a clear;
- a disabled comparator zeroes its counter without touching its flag;
- a non-match leaves the counter alone;
- a set event beats a clear;
- an excluded channel selection never yields a match.

The exact number of matches needed for each limit needs the bench's scenarios, as does the threshold boundary in both conditions. So does the way matches ignored while a flag is pending fail to shorten the next count, and the independence of the two comparators.

// File: rtl/wcm_pkg.sv
// Package: shared constants and the compare-condition encoding for the
// result window compare monitor. Assumes results are unsigned.
package wcm_pkg;
    parameter int WCM_CH_W    = 5;
    parameter int WCM_DATA_W  = 12;
    parameter int WCM_CNT_W   = 4;
    parameter int WCM_CH_LAST = 17;
    parameter int WCM_GAP_LO  = 8;
    parameter int WCM_GAP_HI  = 12;

    typedef enum logic {
        COND_BELOW    = 1'b0,
        COND_AT_ABOVE = 1'b1
    } cond_e;
endpackage

// File: rtl/wcm_match.sv
// Module: wcm_match
// Decides, combinationally, whether the current result is a match for one
// comparator. Assumes res_valid is a one-cycle strobe per result and that
// the selected channel is static while results flow.
module wcm_match
    import wcm_pkg::*;
#(
    parameter int CH_W    = WCM_CH_W,
    parameter int DATA_W  = WCM_DATA_W,
    parameter int CH_LAST = WCM_CH_LAST,
    parameter int GAP_LO  = WCM_GAP_LO,
    parameter int GAP_HI  = WCM_GAP_HI
) (
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [DATA_W-1:0] res_data,
    input  logic              en,
    input  logic              ge,
    input  logic [CH_W-1:0]   sel,
    input  logic [DATA_W-1:0] thresh,
    output logic              hit
);
    localparam logic [CH_W-1:0] LAST_C = CH_W'(CH_LAST);
    localparam logic [CH_W-1:0] LO_C   = CH_W'(GAP_LO);
    localparam logic [CH_W-1:0] HI_C   = CH_W'(GAP_HI);

    logic  sel_ok;
    logic  cond_ok;
    cond_e cond;

    // Purpose: decide whether the selected channel may be compared at all.
    always_comb begin
        sel_ok = (sel <= LAST_C) && !((sel >= LO_C) && (sel <= HI_C));
    end

    // Purpose: apply the chosen condition to the result value.
    always_comb begin
        cond = cond_e'(ge);
        if (cond == COND_AT_ABOVE) cond_ok = (res_data >= thresh);
        else                       cond_ok = (res_data <  thresh);
    end

    // Purpose: combine strobe, enable, channel and condition into one hit.
    always_comb begin
        hit = res_valid && en && sel_ok && (res_chan == sel) && cond_ok;
    end
endmodule

// File: rtl/wcm_counter.sv
// Module: wcm_counter
// Counts hits for one comparator and owns its sticky flag. Assumes clr is a
// single-cycle write-1 pulse and that hit is already qualified by enable.
module wcm_counter
    import wcm_pkg::*;
#(
    parameter int CNT_W = WCM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hit,
    input  logic [CNT_W-1:0] limit,
    input  logic             clr,
    output logic             flag
);
    logic [CNT_W-1:0] cnt;
    logic             set_ev;

    // Purpose: a set happens on a hit that reaches limit+1 while no flag pends.
    always_comb begin
        set_ev = hit && !flag && (cnt >= limit);
    end

    // Purpose: update the match counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (!en)               cnt <= '0;
        else if (set_ev)            cnt <= '0;
        else if (hit && !flag)      cnt <= cnt + CNT_W'(1);
    end

    // Purpose: sticky flag; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (set_ev) flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end

    // R5: counter parked at zero while the flag is pending
    p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> (cnt == '0));

    // R8: flag holds without a clear
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R8: a clear on a pending flag drops it
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr) |=> !flag);

    // R9: disable zeroes the counter and leaves the flag alone
    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> ((cnt == '0) && $stable(flag)));

    // R3: a non-match leaves the counter unchanged
    p_nomatch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !hit) |=> (cnt == $past(cnt)));

    // R10: a set event raises the flag even with a clear present
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !flag && (cnt >= limit)) |=> flag);
endmodule

// File: rtl/wcm_monitor.sv
// Module: wcm_monitor (top)
// Holds NUM_CMP independent threshold comparators over one tagged result
// stream. Assumes configuration fields are driven from a register block and
// clear pulses are one cycle long.
module wcm_monitor
    import wcm_pkg::*;
#(
    parameter int NUM_CMP = 2,
    parameter int CH_W    = WCM_CH_W,
    parameter int DATA_W  = WCM_DATA_W,
    parameter int CNT_W   = WCM_CNT_W,
    parameter int CH_LAST = WCM_CH_LAST,
    parameter int GAP_LO  = WCM_GAP_LO,
    parameter int GAP_HI  = WCM_GAP_HI
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      res_valid,
    input  logic [CH_W-1:0]           res_chan,
    input  logic [DATA_W-1:0]         res_data,
    input  logic [NUM_CMP-1:0]        cfg_en,
    input  logic [NUM_CMP-1:0]        cfg_irq_en,
    input  logic [NUM_CMP-1:0]        cfg_ge,
    input  logic [NUM_CMP*CH_W-1:0]   cfg_chan,
    input  logic [NUM_CMP*CNT_W-1:0]  cfg_limit,
    input  logic [NUM_CMP*DATA_W-1:0] cfg_thresh,
    input  logic [NUM_CMP-1:0]        flag_clr,
    output logic [NUM_CMP-1:0]        cmp_flag,
    output logic [NUM_CMP-1:0]        cmp_irq
);
    localparam logic [CH_W-1:0] LAST_C = CH_W'(CH_LAST);
    localparam logic [CH_W-1:0] LO_C   = CH_W'(GAP_LO);
    localparam logic [CH_W-1:0] HI_C   = CH_W'(GAP_HI);

    logic [NUM_CMP-1:0] hit;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        logic [CH_W-1:0] sel_i;
        assign sel_i = cfg_chan[i*CH_W +: CH_W];

        wcm_match #(
            .CH_W(CH_W), .DATA_W(DATA_W), .CH_LAST(CH_LAST),
            .GAP_LO(GAP_LO), .GAP_HI(GAP_HI)
        ) u_match (
            .res_valid (res_valid),
            .res_chan  (res_chan),
            .res_data  (res_data),
            .en        (cfg_en[i]),
            .ge        (cfg_ge[i]),
            .sel       (sel_i),
            .thresh    (cfg_thresh[i*DATA_W +: DATA_W]),
            .hit       (hit[i])
        );

        wcm_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cfg_en[i]),
            .hit   (hit[i]),
            .limit (cfg_limit[i*CNT_W +: CNT_W]),
            .clr   (flag_clr[i]),
            .flag  (cmp_flag[i])
        );

        // Purpose: gate the pending flag onto the interrupt line.
        always_comb begin
            cmp_irq[i] = cmp_flag[i] & cfg_irq_en[i];
        end

        // R1: the flag can only rise after a qualified hit
        p_no_hit_no_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !hit[i] |=> !$rose(cmp_flag[i]));

        // R6: an excluded or out-of-range selection never yields a hit
        p_excluded_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ((sel_i > LAST_C) || ((sel_i >= LO_C) && (sel_i <= HI_C))) |-> !hit[i]);

        // R7: no interrupt without its enable
        p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_irq_en[i] |-> !cmp_irq[i]);
    end
endmodule

// File: tb/wcm_monitor_test.sv
module wcm_monitor_test;
    localparam int NC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [4:0]  res_chan = '0;
    logic [11:0] res_data = '0;
    logic [1:0]  cfg_en = '0, cfg_irq_en = '0, cfg_ge = '0, flag_clr = '0;
    logic [9:0]  cfg_chan = '0;
    logic [7:0]  cfg_limit = '0;
    logic [23:0] cfg_thresh = '0;
    logic [1:0]  cmp_flag, cmp_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wcm_monitor #(.NUM_CMP(NC)) uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .cfg_en(cfg_en), .cfg_irq_en(cfg_irq_en),
        .cfg_ge(cfg_ge), .cfg_chan(cfg_chan), .cfg_limit(cfg_limit),
        .cfg_thresh(cfg_thresh), .flag_clr(flag_clr),
        .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
    );

    // Vector: {chan[18:14], data[13:2], exp_flag0[1], exp_flag1[0]}
    // Comparator 0: chan 3, at-or-above 0x800, limit 2.
    // Comparator 1: chan 14, below 0x100, limit 0.
    localparam logic [18:0] VEC [8] = '{
        {5'd3,  12'h900, 1'b0, 1'b0},
        {5'd3,  12'h100, 1'b0, 1'b0},
        {5'd5,  12'hFFF, 1'b0, 1'b0},
        {5'd14, 12'h0FF, 1'b0, 1'b1},
        {5'd3,  12'h800, 1'b0, 1'b1},
        {5'd3,  12'h7FF, 1'b0, 1'b1},
        {5'd3,  12'hFFF, 1'b1, 1'b1},
        {5'd14, 12'h100, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic cfg(input int i, input logic en, input logic ie,
                       input logic ge, input logic [4:0] ch,
                       input logic [3:0] lim, input logic [11:0] th);
        cfg_en[i] = en; cfg_irq_en[i] = ie; cfg_ge[i] = ge;
        cfg_chan[i*5 +: 5] = ch; cfg_limit[i*4 +: 4] = lim;
        cfg_thresh[i*12 +: 12] = th;
    endtask

    // One result (and optional clear) for one cycle; returns after the edge.
    task automatic send(input logic v, input logic [4:0] ch,
                        input logic [11:0] d, input logic [1:0] clr);
        @(negedge clk);
        res_valid = v; res_chan = ch; res_data = d; flag_clr = clr;
        @(negedge clk);
        res_valid = 1'b0; flag_clr = '0;
    endtask

    task automatic clear(input logic [1:0] m);
        send(1'b0, 5'd0, 12'h0, m);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 flag0", cmp_flag[0], 1'b0);
        check("R11 flag1", cmp_flag[1], 1'b0);
        check("R11 irq",   |cmp_irq,    1'b0);

        cfg(0, 1, 0, 1, 5'd3,  4'd2, 12'h800);
        cfg(1, 1, 1, 0, 5'd14, 4'd0, 12'h100);

        // R1: matching data without the valid strobe does nothing
        send(1'b0, 5'd14, 12'h000, 2'b00);
        check("R1 no strobe", cmp_flag[1], 1'b0);

        // Table walk: R2 R3 R4 R12
        for (int k = 0; k < 8; k++) begin
            send(1'b1, VEC[k][18:14], VEC[k][13:2], 2'b00);
            check($sformatf("R3 vec%0d flag0", k), cmp_flag[0], VEC[k][1]);
            check($sformatf("R4 vec%0d flag1", k), cmp_flag[1], VEC[k][0]);
        end

        // R7: interrupt follows flag and enable
        check("R7 irq1", cmp_irq[1], 1'b1);
        check("R7 irq0", cmp_irq[0], 1'b0);

        // R5: matches while pending are not counted
        send(1'b1, 5'd3, 12'hFFF, 2'b00);
        send(1'b1, 5'd3, 12'hFFF, 2'b00);
        check("R8 sticky", cmp_flag[0], 1'b1);
        clear(2'b01);
        check("R8 clear", cmp_flag[0], 1'b0);
        check("R12 other flag", cmp_flag[1], 1'b1);
        send(1'b1, 5'd3, 12'hFFF, 2'b00);
        send(1'b1, 5'd3, 12'hFFF, 2'b00);
        check("R5 fresh count", cmp_flag[0], 1'b0);
        send(1'b1, 5'd3, 12'hFFF, 2'b00);
        check("R5 third match", cmp_flag[0], 1'b1);

        // R9: disabling keeps the flag, resets the count
        @(negedge clk); cfg_en[0] = 1'b0;
        @(negedge clk); cfg_en[0] = 1'b1;
        check("R9 flag kept", cmp_flag[0], 1'b1);
        clear(2'b01);
        send(1'b1, 5'd3, 12'hA00, 2'b00);
        send(1'b1, 5'd3, 12'hA00, 2'b00);
        @(negedge clk); cfg_en[0] = 1'b0;
        @(negedge clk); cfg_en[0] = 1'b1;
        send(1'b1, 5'd3, 12'hA00, 2'b00);
        send(1'b1, 5'd3, 12'hA00, 2'b00);
        check("R9 count reset", cmp_flag[0], 1'b0);
        send(1'b1, 5'd3, 12'hA00, 2'b00);
        check("R9 after reset", cmp_flag[0], 1'b1);

        // R1: disabled comparator ignores results
        clear(2'b01);
        @(negedge clk); cfg_en[0] = 1'b0;
        for (int k = 0; k < 3; k++) send(1'b1, 5'd3, 12'hFFF, 2'b00);
        check("R1 disabled", cmp_flag[0], 1'b0);
        @(negedge clk); cfg_en[0] = 1'b1;

        // R10: set and clear in the same cycle
        clear(2'b10);
        check("R10 pre", cmp_flag[1], 1'b0);
        send(1'b1, 5'd14, 12'h000, 2'b10);
        check("R10 set wins", cmp_flag[1], 1'b1);

        // R6: excluded and out-of-range selections
        cfg(1, 1, 1, 1, 5'd10, 4'd0, 12'h000);
        clear(2'b10);
        send(1'b1, 5'd10, 12'h005, 2'b00);
        check("R6 chan10", cmp_flag[1], 1'b0);
        cfg(1, 1, 1, 1, 5'd12, 4'd0, 12'h000);
        send(1'b1, 5'd12, 12'h005, 2'b00);
        check("R6 chan12", cmp_flag[1], 1'b0);
        cfg(1, 1, 1, 1, 5'd20, 4'd0, 12'h000);
        send(1'b1, 5'd20, 12'h005, 2'b00);
        check("R6 chan20", cmp_flag[1], 1'b0);
        cfg(1, 1, 1, 1, 5'd13, 4'd0, 12'h000);
        send(1'b1, 5'd13, 12'h005, 2'b00);
        check("R6 chan13", cmp_flag[1], 1'b1);
        cfg(1, 1, 1, 1, 5'd17, 4'd0, 12'h000);
        clear(2'b10);
        send(1'b1, 5'd17, 12'h000, 2'b00);
        check("R6 chan17", cmp_flag[1], 1'b1);

        // R2: below-threshold boundary
        cfg(1, 1, 0, 0, 5'd14, 4'd0, 12'h100);
        clear(2'b10);
        send(1'b1, 5'd14, 12'h100, 2'b00);
        check("R2 equal not below", cmp_flag[1], 1'b0);
        check("R7 irq off", cmp_irq[1], 1'b0);
        send(1'b1, 5'd14, 12'h0FF, 2'b00);
        check("R2 below", cmp_flag[1], 1'b1);

        finish_run();
    end
endmodule